// File: doc/BRIEF.md
# Bidirectional Row Scan Gate Sequencer

This block drives the row lines of an active-matrix pixel array with a configurable number of rows. A single token walks through the rows, one row per row time. Each row time is marked by a one-cycle tick. For every row, the block produces a row-select that stays high for two row times, so neighbouring selects overlap by one row time. It also produces a gate pulse that is one row time wide. The gate pulses never overlap, because each select is ANDed with one of two complementary enable phases: one phase serves even-numbered rows and the other serves odd-numbered rows. The block generates both phases itself and brings them out as outputs.

A frame-start pulse launches a scan. At that moment the block captures a direction bit. That bit chooses whether the scan begins at row 0 and counts upward, or begins at the highest row and counts downward. Once the last select has dropped, the outputs stay quiet until the next frame start. Every output is registered, so each output changes on the clock edge that samples the tick or start pulse that caused the change.

Top module: `rs_gate_sequencer`

## Requirements
- R1: While reset is high, and after reset until the first frame start, every select, every gate and both enable phases are low.
- R2: On the edge that samples `frame_start_i` high, the select of the first row rises alone. The first row is row 0 when `scan_up_i` is 0 and row N-1 when it is 1. Each later tick moves the token one row onward: to higher indices for 0, to lower indices for 1.
- R3: Each row's select is high for exactly two row times, counted from the start or tick that raises it until the second tick after that. It overlaps the next row's select by one row time, and no more than two selects are ever high together.
- R4: A gate output is high only while its select is high and its enable phase is high. Rows with an even index use `en_even_o`; rows with an odd index use `en_odd_o`.
- R5: While a frame is active, exactly one of the two enable phases is high, and they swap at every tick. `en_even_o` is high in the first row time if the first row has an even index. Both phases are low when no select is high.
- R6: Each row's gate is high only during the first row time of its select, and at most one gate is high at any moment.
- R7: The block samples `scan_up_i` only on a frame start. A change of this input during a frame does not affect that frame's scan.
- R8: After the last row's select falls, which happens N+1 ticks after the frame start, all outputs remain low. Further ticks have no effect until the next frame start.
- R9: A frame start that arrives during an active frame drops all current selects at once and restarts the scan at the first row, in the newly sampled direction.
- R10: If a tick and a frame start arrive in the same cycle, the block ignores the tick and the new frame starts at its first row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_tick_i | input | 1 | One-cycle pulse marking each row-time boundary |
| frame_start_i | input | 1 | One-cycle pulse that starts a new scan |
| scan_up_i | input | 1 | Scan direction: 0 starts at row 0 and ascends, 1 starts at row N-1 and descends |
| sel_o | output | N_ROWS | Row-select vector, two row times per row |
| gate_o | output | N_ROWS | Gate vector, one row time per row |
| en_even_o | output | 1 | Enable phase for even-indexed rows |
| en_odd_o | output | 1 | Enable phase for odd-indexed rows |

## Verification
The bench compares full output vectors against an independent model of row positions, in both scan directions. It waits between ticks to confirm that the outputs hold, and it covers the row time after the token has left the array, when only the last select remains and no gate may fire. A design that latched the direction continuously would bend the scan when `scan_up_i` flips mid-frame. A design that let a tick win over a simultaneous frame start would begin one row late. A design that picked the wrong starting phase for a descending scan would gate the wrong row of each overlapping pair. Extra ticks after a frame ends, and a restart during a frame, check that no stale select lingers.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic {
    SCAN_ASCEND  = 1'b0,
    SCAN_DESCEND = 1'b1
  } scan_dir_e;
endpackage

// File: rtl/rs_token_ctrl.sv
module rs_token_ctrl #(
  parameter int N_ROWS = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              adv,
  input  logic              dir_in,
  output logic [N_ROWS-1:0] tok_nxt,
  output logic [N_ROWS-1:0] trail_nxt,
  output rs_pkg::scan_dir_e dir_nxt
);
  import rs_pkg::*;

  localparam logic [N_ROWS-1:0] HEAD_ASC  = {{(N_ROWS-1){1'b0}}, 1'b1};
  localparam logic [N_ROWS-1:0] HEAD_DESC = {1'b1, {(N_ROWS-1){1'b0}}};

  logic [N_ROWS-1:0] tok_q;
  logic [N_ROWS-1:0] trail_q;
  scan_dir_e         dir_q;

  always_comb begin
    dir_nxt   = start ? scan_dir_e'(dir_in) : dir_q;
    tok_nxt   = tok_q;
    trail_nxt = trail_q;
    if (start) begin
      tok_nxt   = (dir_nxt == SCAN_ASCEND) ? HEAD_ASC : HEAD_DESC;
      trail_nxt = '0;
    end else if (adv) begin
      tok_nxt   = (dir_q == SCAN_ASCEND) ? (tok_q << 1) : (tok_q >> 1);
      trail_nxt = tok_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tok_q   <= '0;
      trail_q <= '0;
      dir_q   <= SCAN_ASCEND;
    end else begin
      tok_q   <= tok_nxt;
      trail_q <= trail_nxt;
      dir_q   <= dir_nxt;
    end
  end

  AST_TOKEN_ONEHOT0: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tok_q)); // R2

  AST_DIR_HELD: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(dir_q)); // R7
endmodule

// File: rtl/rs_phase_gen.sv
module rs_phase_gen #(
  parameter int N_ROWS = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              adv,
  input  rs_pkg::scan_dir_e dir_nxt,
  output logic              even_nxt
);
  import rs_pkg::*;

  localparam logic LAST_ROW_EVEN = ((N_ROWS - 1) % 2) == 0;

  logic even_q;

  always_comb begin
    even_nxt = even_q;
    if (start) begin
      even_nxt = (dir_nxt == SCAN_ASCEND) ? 1'b1 : LAST_ROW_EVEN;
    end else if (adv) begin
      even_nxt = ~even_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      even_q <= 1'b1;
    end else begin
      even_q <= even_nxt;
    end
  end

  AST_PHASE_TOGGLES: assert property (@(posedge clk) disable iff (rst)
    (adv && !start) |=> (even_q != $past(even_q))); // R5
endmodule

// File: rtl/rs_gate_mask.sv
module rs_gate_mask #(
  parameter int N_ROWS = 1024
) (
  input  logic [N_ROWS-1:0] sel,
  input  logic              en_even,
  input  logic              en_odd,
  output logic [N_ROWS-1:0] gate
);
  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    if ((r % 2) == 0) begin : g_even
      assign gate[r] = sel[r] & en_even;
    end else begin : g_odd
      assign gate[r] = sel[r] & en_odd;
    end
  end
endmodule

// File: rtl/rs_gate_sequencer.sv
module rs_gate_sequencer #(
  parameter int N_ROWS = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              row_tick_i,
  input  logic              frame_start_i,
  input  logic              scan_up_i,
  output logic [N_ROWS-1:0] sel_o,
  output logic [N_ROWS-1:0] gate_o,
  output logic              en_even_o,
  output logic              en_odd_o
);
  import rs_pkg::*;

  logic              start;
  logic              adv;
  logic [N_ROWS-1:0] tok_nxt;
  logic [N_ROWS-1:0] trail_nxt;
  scan_dir_e         dir_nxt;
  logic              even_nxt;
  logic [N_ROWS-1:0] sel_nxt;
  logic              active_nxt;
  logic              en_even_nxt;
  logic              en_odd_nxt;
  logic [N_ROWS-1:0] gate_nxt;

  assign start = frame_start_i;
  assign adv   = row_tick_i & ~frame_start_i;

  rs_token_ctrl #(.N_ROWS(N_ROWS)) i_token (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .adv       (adv),
    .dir_in    (scan_up_i),
    .tok_nxt   (tok_nxt),
    .trail_nxt (trail_nxt),
    .dir_nxt   (dir_nxt)
  );

  rs_phase_gen #(.N_ROWS(N_ROWS)) i_phase (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .adv      (adv),
    .dir_nxt  (dir_nxt),
    .even_nxt (even_nxt)
  );

  assign sel_nxt     = tok_nxt | trail_nxt;
  assign active_nxt  = |sel_nxt;
  assign en_even_nxt = active_nxt & even_nxt;
  assign en_odd_nxt  = active_nxt & ~even_nxt;

  rs_gate_mask #(.N_ROWS(N_ROWS)) i_mask (
    .sel     (sel_nxt),
    .en_even (en_even_nxt),
    .en_odd  (en_odd_nxt),
    .gate    (gate_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_o     <= '0;
      gate_o    <= '0;
      en_even_o <= 1'b0;
      en_odd_o  <= 1'b0;
    end else begin
      sel_o     <= sel_nxt;
      gate_o    <= gate_nxt;
      en_even_o <= en_even_nxt;
      en_odd_o  <= en_odd_nxt;
    end
  end

  AST_SEL_AT_MOST_TWO: assert property (@(posedge clk) disable iff (rst)
    $countones(sel_o) <= 2); // R3

  AST_GATE_INSIDE_SEL: assert property (@(posedge clk) disable iff (rst)
    (gate_o & ~sel_o) == '0); // R4

  AST_PHASES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(en_even_o && en_odd_o)); // R5

  AST_GATE_ONEHOT0: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gate_o)); // R6

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (sel_o == '0 && !frame_start_i) |=> (sel_o == '0 && gate_o == '0)); // R8
endmodule

// File: tb/test_rs_gate_sequencer.sv
module test_rs_gate_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         row_tick = 1'b0;
  logic         frame_start = 1'b0;
  logic         scan_up = 1'b0;
  logic [N-1:0] sel;
  logic [N-1:0] gate;
  logic         en_even;
  logic         en_odd;

  typedef struct {
    logic [N-1:0] sel;
    logic [N-1:0] gate;
    logic         ev;
    logic         od;
    string        tag;
  } exp_t;

  exp_t q[$];
  event ev_chk;
  int   n_checks = 0;
  int   n_fail = 0;
  int   k = 0;
  bit   up = 1'b0;
  bit   live = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rs_gate_sequencer #(.N_ROWS(N)) i_rs_gate_sequencer (
    .clk           (clk),
    .rst           (rst),
    .row_tick_i    (row_tick),
    .frame_start_i (frame_start),
    .scan_up_i     (scan_up),
    .sel_o         (sel),
    .gate_o        (gate),
    .en_even_o     (en_even),
    .en_odd_o      (en_odd)
  );

  function automatic exp_t model_out(string tag);
    exp_t e;
    int p;
    e.sel = '0; e.gate = '0; e.ev = 1'b0; e.od = 1'b0; e.tag = tag;
    if (live && k <= N) begin
      for (int j = 0; j < N; j++) begin
        int ph;
        ph = up ? (N - 1 - j) : j;
        if (j == k || j == k - 1) e.sel[ph] = 1'b1;
        if (j == k) e.gate[ph] = 1'b1;
      end
      p = up ? (N - 1 - k) : k;
      if ((p % 2) == 0) e.ev = 1'b1; else e.od = 1'b1;
    end
    return e;
  endfunction

  task automatic push(string tag);
    q.push_back(model_out(tag));
    -> ev_chk;
    #1;
  endtask

  task automatic do_start(bit d, bit with_tick, string tag);
    @(negedge clk);
    frame_start = 1'b1; scan_up = d; row_tick = with_tick;
    @(negedge clk);
    frame_start = 1'b0; row_tick = 1'b0;
    up = d; k = 0; live = 1'b1;
    push(tag);
  endtask

  task automatic do_tick(string tag);
    @(negedge clk);
    row_tick = 1'b1;
    @(negedge clk);
    row_tick = 1'b0;
    if (live) begin
      k++;
      if (k > N) live = 1'b0;
    end
    push(tag);
  endtask

  task automatic hold(int n, string tag);
    repeat (n) @(negedge clk);
    push(tag);
  endtask

  task automatic check_field(bit ok, string tag, string what, logic [N-1:0] act, logic [N-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(ev_chk);
      while (q.size() > 0) begin
        e = q.pop_front();
        check_field(sel === e.sel, e.tag, "select (R3)", sel, e.sel);
        check_field(gate === e.gate, e.tag, "gate (R6)", gate, e.gate);
        check_field({en_even, en_odd} === {e.ev, e.od}, e.tag, "enables (R5)",
                    N'({en_even, en_odd}), N'({e.ev, e.od}));
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    push("R1 in reset");
    rst = 1'b0;
    hold(2, "R1 after reset");
    do_tick("R1 tick before any frame");

    // ascending frame, with holds between ticks
    do_start(1'b0, 1'b0, "R2 ascending start");
    hold(3, "R3 hold first row time");
    for (int i = 0; i < N + 1; i++) begin
      do_tick("R4 ascending step");
      if (i % 3 == 0) hold(2, "R6 hold mid-frame");
    end
    hold(2, "R8 idle after ascending frame");
    do_tick("R8 extra tick ignored");
    do_tick("R8 second extra tick ignored");

    // descending frame, direction input flips mid-frame
    do_start(1'b1, 1'b0, "R2 descending start");
    do_tick("R5 descending step");
    do_tick("R5 descending step");
    @(negedge clk); scan_up = 1'b0;
    for (int i = 0; i < N; i++) do_tick("R7 direction flip ignored");
    hold(2, "R8 idle after descending frame");

    // restart during an active frame
    do_start(1'b0, 1'b0, "R9 first frame");
    do_tick("R9 step");
    do_tick("R9 step");
    do_tick("R9 step");
    do_start(1'b1, 1'b0, "R9 restart mid-frame");
    do_tick("R9 step after restart");
    do_tick("R9 step after restart");

    // start and tick in the same cycle
    do_start(1'b0, 1'b1, "R10 start wins over tick");
    for (int i = 0; i < N + 1; i++) do_tick("R10 step");
    hold(2, "R8 idle at end");

    #1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule